// File: doc/BRIEF.md
# ARINC 429 receive channel

This block is one receive channel for ARINC 429 traffic. The line arrives already split into two return-to-zero signals, one that pulses for a one bit and one that pulses for a zero bit. The channel samples both signals on a fast local clock and rebuilds the bit timing from the pulses. It shifts the bits into a 32-bit register and finds the end of each word when the line has been idle for a programmed number of sampling cycles.

At the end of a word the channel checks four things: the bit count, the parity, whether the label is accepted and whether the output buffer is free. A word that passes all four is copied into a one-deep buffer, which the host reads as two 16-bit halves. A good word that arrives while the buffer is occupied waits in the shift register and moves in once the host frees the buffer. A word that fails only on parity can set a sticky flag.

The host configures the channel through a control register, a gap register and a 256 x 1 label acceptance memory. A loopback select lets a second pair of lines feed the channel in place of the external pair.

Top module: `a429_rx_channel`

## Requirements
- R1: After reset, the valid flag, the wrong-parity flag, the interrupt request and the control register read back 0.
- R2: With only the one-line high the channel counts a 1 bit, and with only the zero-line high it counts a 0 bit. A period with both lines high is null and adds no bit. Bits fill the word least significant bit first. An accepted word appears as buf_hi_o = word[31:16] and buf_lo_o = word[15:0].
- R3: A word is evaluated only after the line has been null for the number of sampling cycles held in the gap register. Before that, the valid flag stays 0.
- R4: A word whose bit count is not exactly 32 is discarded without any flag changing.
- R5: When control bit 5 (parity check) is 1, a word is rejected unless the number of ones in all 32 bits is odd when control bit 4 is 1, or even when control bit 4 is 0. When bit 5 is 0, parity is not checked.
- R6: When control bit 6 is 1 and a 32-bit word fails only on parity, perr_o is set and stays set until a perr_clr_i pulse. When bit 6 is 0, the same word leaves perr_o at 0.
- R7: When control bit 2 (label check) is 1, a word is accepted only if the memory entry addressed by word[7:0] is 1.
- R8: A label memory write takes effect only while control bit 3 is 1; otherwise it is ignored. lbl_rdata_o shows the entry at lbl_addr_i.
- R9: While the buffer is valid, its contents do not change. A good word that arrives meanwhile is held, and it enters the buffer two cycles after the rd_lo_i pulse.
- R10: A rd_lo_i pulse while the buffer is valid clears the valid flag on the next cycle.
- R11: When control bit 0 (channel enable) is 0, line activity is ignored and no word is accepted.
- R12: When control bit 1 (loopback) is 1, the channel takes its bits from lb_one_i/lb_zero_i and ignores rx_one_i/rx_zero_i.
- R13: irq_o is 1 exactly when the buffer is valid and control bit 7 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_one_i | input | 1 | External one-line |
| rx_zero_i | input | 1 | External zero-line |
| lb_one_i | input | 1 | Loopback one-line |
| lb_zero_i | input | 1 | Loopback zero-line |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_o | output | 8 | Control register contents |
| gap_we_i | input | 1 | Gap register write strobe |
| gap_wdata_i | input | 8 | Gap value in sampling cycles |
| lbl_we_i | input | 1 | Label memory write strobe |
| lbl_addr_i | input | 8 | Label memory address |
| lbl_wdata_i | input | 1 | Label memory write data |
| lbl_rdata_o | output | 1 | Label memory entry at lbl_addr_i |
| rd_lo_i | input | 1 | Low-half read strobe; frees the buffer |
| buf_hi_o | output | 16 | Buffered word bits 31..16 |
| buf_lo_o | output | 16 | Buffered word bits 15..0 |
| buf_valid_o | output | 1 | Buffer holds an unread word |
| perr_o | output | 1 | Sticky wrong-parity flag |
| perr_clr_i | input | 1 | Clears the wrong-parity flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach is a good word held in the shift register while the buffer is still occupied, followed by its late move into the buffer. The bench reaches it by sending two complete serial words back to back without reading in between. It checks that the buffer still shows the first word, then pulses the low-half read and checks the valid flag both one and two cycles later. Gap timing is exercised by sampling the valid flag before and after the programmed idle time following the last bit. A both-lines-high pulse is placed inside a word to show that it adds no bit.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
   // control register bit positions
   localparam int CB_EN    = 0;
   localparam int CB_LOOP  = 1;
   localparam int CB_LCHK  = 2;
   localparam int CB_LWE   = 3;
   localparam int CB_PODD  = 4;
   localparam int CB_PCHK  = 5;
   localparam int CB_PERR  = 6;
   localparam int CB_IRQ   = 7;
   localparam int CB_COUNT = 8;

   typedef enum logic [1:0] {
      LS_NULL = 2'd0,
      LS_ONE  = 2'd1,
      LS_ZERO = 2'd2
   } line_state_t;
endpackage

// File: rtl/a429_rx_line.sv
module a429_rx_line
   import a429_rx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic one_i,
   input  logic zero_i,
   input  logic en_i,
   output logic active_o,
   output logic bit_stb_o,
   output logic bit_val_o,
   output logic fall_stb_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("a429_rx_line: STAGES must be at least 2");
   end

   logic [STAGES-1:0] one_ff, zero_ff;
   logic              act_q;
   line_state_t       st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         one_ff  <= '0;
         zero_ff <= '0;
      end else begin
         one_ff  <= {one_ff[STAGES-2:0], one_i};
         zero_ff <= {zero_ff[STAGES-2:0], zero_i};
      end
   end

   always_comb begin
      st = LS_NULL;
      if (en_i) begin
         unique case ({one_ff[STAGES-1], zero_ff[STAGES-1]})
            2'b10:   st = LS_ONE;
            2'b01:   st = LS_ZERO;
            default: st = LS_NULL;
         endcase
      end
   end

   assign active_o = (st != LS_NULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= active_o;
   end

   assign bit_stb_o  = active_o & ~act_q;
   assign bit_val_o  = (st == LS_ONE);
   assign fall_stb_o = ~active_o & act_q;
endmodule

// File: rtl/a429_rx_gap.sv
module a429_rx_gap #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             fall_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             eom_o
);
   if (GAP_W < 2) begin : g_bad_gap
      $error("a429_rx_gap: GAP_W must be at least 2");
   end

   logic [GAP_W-1:0] cnt_q;
   logic             armed_q;

   assign eom_o = armed_q & ~active_i & ~fall_i & (cnt_q == gap_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (fall_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (active_i) begin
         cnt_q   <= '0;
      end else if (eom_o) begin
         armed_q <= 1'b0;
      end else if (armed_q) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   AST_EOM_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      eom_o |=> !eom_o); // R3
endmodule

// File: rtl/a429_rx_lblmem.sv
module a429_rx_lblmem #(
   parameter int LBL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [LBL_W-1:0] waddr_i,
   input  logic             wdata_i,
   input  logic [LBL_W-1:0] host_addr_i,
   output logic             host_rdata_o,
   input  logic [LBL_W-1:0] rx_label_i,
   output logic             rx_hit_o
);
   localparam int DEPTH = 1 << LBL_W;

   if (LBL_W > 10) begin : g_bad_lbl
      $error("a429_rx_lblmem: LBL_W too large for a flop memory");
   end

   logic [DEPTH-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem_q <= '0;
      else if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   assign host_rdata_o = mem_q[host_addr_i];
   assign rx_hit_o     = mem_q[rx_label_i];

   AST_LBL_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mem_q)); // R8
endmodule

// File: rtl/a429_rx_channel.sv
module a429_rx_channel
   import a429_rx_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int LBL_W       = 8,
   parameter int GAP_W       = 8,
   parameter int GAP_RST     = 12,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_W       = 8,
   parameter bit HAS_LBL_MEM = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_one_i,
   input  logic                  rx_zero_i,
   input  logic                  lb_one_i,
   input  logic                  lb_zero_i,
   input  logic                  cfg_we_i,
   input  logic [CFG_W-1:0]      cfg_wdata_i,
   output logic [CFG_W-1:0]      cfg_o,
   input  logic                  gap_we_i,
   input  logic [GAP_W-1:0]      gap_wdata_i,
   input  logic                  lbl_we_i,
   input  logic [LBL_W-1:0]      lbl_addr_i,
   input  logic                  lbl_wdata_i,
   output logic                  lbl_rdata_o,
   input  logic                  rd_lo_i,
   output logic [WORD_W/2-1:0]   buf_hi_o,
   output logic [WORD_W/2-1:0]   buf_lo_o,
   output logic                  buf_valid_o,
   output logic                  perr_o,
   input  logic                  perr_clr_i,
   output logic                  irq_o
);
   localparam int HALF_W = WORD_W / 2;
   localparam int CNT_W  = $clog2(WORD_W + 1) + 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

   if (WORD_W % 2 != 0 || WORD_W <= LBL_W) begin : g_bad_word
      $error("a429_rx_channel: WORD_W must be even and wider than LBL_W");
   end
   if (CFG_W < CB_COUNT) begin : g_bad_cfg
      $error("a429_rx_channel: CFG_W too narrow for the control bits");
   end
   if (GAP_RST >= (1 << GAP_W)) begin : g_bad_gaprst
      $error("a429_rx_channel: GAP_RST does not fit GAP_W");
   end

   // configuration
   logic [CFG_W-1:0] cfg_q;
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         gap_q <= GAP_W'(GAP_RST);
      end else begin
         if (cfg_we_i) cfg_q <= cfg_wdata_i;
         if (gap_we_i) gap_q <= gap_wdata_i;
      end
   end
   assign cfg_o = cfg_q;

   wire en      = cfg_q[CB_EN];
   wire in_one  = cfg_q[CB_LOOP] ? lb_one_i  : rx_one_i;
   wire in_zero = cfg_q[CB_LOOP] ? lb_zero_i : rx_zero_i;

   // bit clock recovery and end-of-message detection
   logic active, bit_stb, bit_val, fall_stb, eom;

   a429_rx_line #(.STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .one_i(in_one), .zero_i(in_zero), .en_i(en),
      .active_o(active), .bit_stb_o(bit_stb), .bit_val_o(bit_val),
      .fall_stb_o(fall_stb)
   );

   a429_rx_gap #(.GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .active_i(active), .fall_i(fall_stb),
      .gap_i(gap_q), .eom_o(eom)
   );

   // shift register and bit count
   logic [WORD_W-1:0] shift_q;
   logic [CNT_W-1:0]  bcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         bcnt_q  <= '0;
      end else if (!en) begin
         bcnt_q  <= '0;
      end else if (bit_stb) begin
         shift_q <= {bit_val, shift_q[WORD_W-1:1]};
         if (bcnt_q != '1) bcnt_q <= bcnt_q + 1'b1;
      end else if (eom) begin
         bcnt_q  <= '0;
      end
   end

   // label acceptance, variant chosen by parameter
   logic lbl_hit;
   if (HAS_LBL_MEM) begin : g_lblmem
      a429_rx_lblmem #(.LBL_W(LBL_W)) u_lbl (
         .clk(clk), .rst_n(rst_n),
         .we_i(lbl_we_i & cfg_q[CB_LWE]), .waddr_i(lbl_addr_i),
         .wdata_i(lbl_wdata_i), .host_addr_i(lbl_addr_i),
         .host_rdata_o(lbl_rdata_o), .rx_label_i(shift_q[LBL_W-1:0]),
         .rx_hit_o(lbl_hit)
      );
   end else begin : g_nolblmem
      assign lbl_hit     = 1'b1;
      assign lbl_rdata_o = 1'b0;
   end

   // word checks
   wire cnt_ok  = (bcnt_q == FULL_CNT);
   wire par_ok  = ~cfg_q[CB_PCHK] | ((^shift_q) == cfg_q[CB_PODD]);
   wire lbl_ok  = ~cfg_q[CB_LCHK] | lbl_hit;
   wire good    = cnt_ok & par_ok & lbl_ok;
   wire par_bad = cnt_ok & lbl_ok & ~par_ok;

   // buffer, hold and flags
   logic [WORD_W-1:0] buf_q;
   logic              valid_q, hold_q, perr_q;

   wire load = ~valid_q & ((eom & good) | hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         valid_q <= 1'b0;
         hold_q  <= 1'b0;
         perr_q  <= 1'b0;
      end else begin
         if (load) begin
            buf_q   <= shift_q;
            valid_q <= 1'b1;
         end else if (rd_lo_i) begin
            valid_q <= 1'b0;
         end

         if (!en || bit_stb || load)   hold_q <= 1'b0;
         else if (eom && good)         hold_q <= 1'b1;

         if (eom && par_bad && cfg_q[CB_PERR]) perr_q <= 1'b1;
         else if (perr_clr_i)                   perr_q <= 1'b0;
      end
   end

   assign buf_hi_o    = buf_q[WORD_W-1:HALF_W];
   assign buf_lo_o    = buf_q[HALF_W-1:0];
   assign buf_valid_o = valid_q;
   assign perr_o      = perr_q;
   assign irq_o       = valid_q & cfg_q[CB_IRQ];

   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo_i && buf_valid_o) |=> !buf_valid_o); // R10
   AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid_o && !rd_lo_i) |=> (buf_valid_o && $stable(buf_hi_o) && $stable(buf_lo_o))); // R9
   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_o && !perr_clr_i) |=> perr_o); // R6
   AST_NO_BIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_o[CB_EN] |-> !u_line.bit_stb_o); // R11
endmodule

// File: tb/tb_a429_rx_channel.sv
`timescale 1ns/1ps
module tb_a429_rx_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_one_i = 0, rx_zero_i = 0, lb_one_i = 0, lb_zero_i = 0;
   logic        cfg_we_i = 0;
   logic [7:0]  cfg_wdata_i = '0;
   logic [7:0]  cfg_o;
   logic        gap_we_i = 0;
   logic [7:0]  gap_wdata_i = '0;
   logic        lbl_we_i = 0;
   logic [7:0]  lbl_addr_i = '0;
   logic        lbl_wdata_i = 0;
   logic        lbl_rdata_o;
   logic        rd_lo_i = 0;
   logic [15:0] buf_hi_o, buf_lo_o;
   logic        buf_valid_o, perr_o, irq_o;
   logic        perr_clr_i = 0;

   int checks = 0, failures = 0;
   bit done = 0;
   bit use_lb = 0;

   localparam logic [7:0] EN = 8'h01, LOOP = 8'h02, LCHK = 8'h04, LWE = 8'h08,
                          PODD = 8'h10, PCHK = 8'h20, PERR = 8'h40, IRQ = 8'h80;

   always #2.5 clk = ~clk;

   a429_rx_channel dut (
      .clk(clk), .rst_n(rst_n), .rx_one_i(rx_one_i), .rx_zero_i(rx_zero_i),
      .lb_one_i(lb_one_i), .lb_zero_i(lb_zero_i), .cfg_we_i(cfg_we_i),
      .cfg_wdata_i(cfg_wdata_i), .cfg_o(cfg_o), .gap_we_i(gap_we_i),
      .gap_wdata_i(gap_wdata_i), .lbl_we_i(lbl_we_i), .lbl_addr_i(lbl_addr_i),
      .lbl_wdata_i(lbl_wdata_i), .lbl_rdata_o(lbl_rdata_o), .rd_lo_i(rd_lo_i),
      .buf_hi_o(buf_hi_o), .buf_lo_o(buf_lo_o), .buf_valid_o(buf_valid_o),
      .perr_o(perr_o), .perr_clr_i(perr_clr_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_lines(input logic one, input logic zero, input int n);
      @(negedge clk);
      if (use_lb) begin lb_one_i = one; lb_zero_i = zero; end
      else        begin rx_one_i = one; rx_zero_i = zero; end
      repeat (n - 1) @(negedge clk);
   endtask

   // sends nbits of w LSB first; optional both-high pulse before bit 10
   task automatic send_word(input logic [31:0] w, input int nbits, input bit dual_pulse);
      for (int i = 0; i < nbits; i++) begin
         if (dual_pulse && i == 10) begin
            set_lines(1, 1, 4);
            set_lines(0, 0, 4);
         end
         if (w[i % 32]) set_lines(1, 0, 4);
         else           set_lines(0, 1, 4);
         set_lines(0, 0, 4);
      end
   endtask

   task automatic settle();
      repeat (30) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk); cfg_we_i = 1; cfg_wdata_i = v;
      @(negedge clk); cfg_we_i = 0;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_lo_i = 1;
      @(negedge clk); rd_lo_i = 0;
   endtask

   task automatic write_lbl(input logic [7:0] a, input logic d);
      @(negedge clk); lbl_we_i = 1; lbl_addr_i = a; lbl_wdata_i = d;
      @(negedge clk); lbl_we_i = 0;
   endtask

   function automatic logic [31:0] with_par(input logic [31:0] w, input bit odd);
      logic [31:0] r = {1'b0, w[30:0]};
      if ((^r) != odd) r[31] = 1'b1;
      return r;
   endfunction

   task automatic t_reset();
      chk("R1 valid", {31'd0, buf_valid_o}, 32'd0);
      chk("R1 perr", {31'd0, perr_o}, 32'd0);
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      chk("R1 cfg", {24'd0, cfg_o}, 32'd0);
   endtask

   task automatic t_basic();
      logic [31:0] w = 32'hC3A5_1E5A;
      @(negedge clk); gap_we_i = 1; gap_wdata_i = 8'd12;
      @(negedge clk); gap_we_i = 0;
      write_cfg(EN);
      send_word(w, 32, 0);
      settle();
      chk("R2 valid", {31'd0, buf_valid_o}, 32'd1);
      chk("R2 word", {buf_hi_o, buf_lo_o}, w);
      chk("R13 irq masked", {31'd0, irq_o}, 32'd0);
      write_cfg(EN | IRQ);
      chk("R13 irq enabled", {31'd0, irq_o}, 32'd1);
      pulse_rd();
      chk("R10 released", {31'd0, buf_valid_o}, 32'd0);
      chk("R13 irq after read", {31'd0, irq_o}, 32'd0);
      write_cfg(EN);
   endtask

   task automatic t_gap();
      logic [31:0] w = 32'h0F0F_7788;
      send_word(w, 32, 0);
      chk("R3 before gap", {31'd0, buf_valid_o}, 32'd0);
      repeat (2) @(negedge clk);
      chk("R3 still waiting", {31'd0, buf_valid_o}, 32'd0);
      settle();
      chk("R3 after gap", {buf_hi_o, buf_lo_o}, w);
      pulse_rd();
   endtask

   task automatic t_null_pulse();
      logic [31:0] w = 32'h1357_9BDF;
      send_word(w, 32, 1);
      settle();
      chk("R2 both-high null", {buf_hi_o, buf_lo_o}, w);
      chk("R2 both-high valid", {31'd0, buf_valid_o}, 32'd1);
      pulse_rd();
   endtask

   task automatic t_count();
      send_word(32'hFFFF_0000, 31, 0);
      settle();
      chk("R4 31 bits", {31'd0, buf_valid_o}, 32'd0);
      send_word(32'hFFFF_0000, 33, 0);
      settle();
      chk("R4 33 bits", {31'd0, buf_valid_o}, 32'd0);
      chk("R4 no perr", {31'd0, perr_o}, 32'd0);
   endtask

   task automatic t_parity();
      logic [31:0] good_w = with_par(32'h2468_ACE1, 1);
      logic [31:0] bad_w  = with_par(32'h2468_ACE1, 0);
      write_cfg(EN | PCHK | PODD | PERR);
      send_word(good_w, 32, 0);
      settle();
      chk("R5 odd accepted", {buf_hi_o, buf_lo_o}, good_w);
      pulse_rd();
      send_word(bad_w, 32, 0);
      settle();
      chk("R5 even rejected", {31'd0, buf_valid_o}, 32'd0);
      chk("R6 perr set", {31'd0, perr_o}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R6 perr sticky", {31'd0, perr_o}, 32'd1);
      @(negedge clk); perr_clr_i = 1;
      @(negedge clk); perr_clr_i = 0;
      chk("R6 perr cleared", {31'd0, perr_o}, 32'd0);
      write_cfg(EN | PCHK);
      send_word(bad_w, 32, 0);
      settle();
      chk("R5 even sense accepts", {buf_hi_o, buf_lo_o}, bad_w);
      pulse_rd();
      send_word(good_w, 32, 0);
      settle();
      chk("R5 even sense rejects", {31'd0, buf_valid_o}, 32'd0);
      chk("R6 detection off", {31'd0, perr_o}, 32'd0);
      write_cfg(EN);
   endtask

   task automatic t_label();
      logic [31:0] ok_w = 32'h55AA_33A5;
      logic [31:0] no_w = 32'h55AA_333C;
      write_lbl(8'h3C, 1);
      @(negedge clk); lbl_addr_i = 8'h3C;
      #1 chk("R8 write ignored", {31'd0, lbl_rdata_o}, 32'd0);
      write_cfg(EN | LWE);
      write_lbl(8'hA5, 1);
      @(negedge clk); lbl_addr_i = 8'hA5;
      #1 chk("R8 write taken", {31'd0, lbl_rdata_o}, 32'd1);
      write_cfg(EN | LCHK);
      send_word(ok_w, 32, 0);
      settle();
      chk("R7 label accepted", {buf_hi_o, buf_lo_o}, ok_w);
      pulse_rd();
      send_word(no_w, 32, 0);
      settle();
      chk("R7 label rejected", {31'd0, buf_valid_o}, 32'd0);
      write_cfg(EN);
   endtask

   task automatic t_hold();
      logic [31:0] a = 32'hAAAA_0001;
      logic [31:0] b = 32'hBBBB_0002;
      send_word(a, 32, 0);
      settle();
      send_word(b, 32, 0);
      settle();
      chk("R9 first kept", {buf_hi_o, buf_lo_o}, a);
      pulse_rd();
      chk("R10 freed", {31'd0, buf_valid_o}, 32'd0);
      @(negedge clk);
      chk("R9 held moved in", {31'd0, buf_valid_o}, 32'd1);
      chk("R9 held word", {buf_hi_o, buf_lo_o}, b);
      pulse_rd();
   endtask

   task automatic t_disable_loop();
      write_cfg(8'h00);
      send_word(32'h1111_2222, 32, 0);
      settle();
      chk("R11 disabled", {31'd0, buf_valid_o}, 32'd0);
      write_cfg(EN | LOOP);
      use_lb = 1;
      send_word(32'h7654_3210, 32, 0);
      settle();
      chk("R12 loopback word", {buf_hi_o, buf_lo_o}, 32'h7654_3210);
      pulse_rd();
      use_lb = 0;
      send_word(32'h0BAD_0BAD, 32, 0);
      settle();
      chk("R12 external ignored", {31'd0, buf_valid_o}, 32'd0);
      write_cfg(EN);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_gap();
      t_null_pulse();
      t_count();
      t_parity();
      t_label();
      t_hold();
      t_disable_loop();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule